// File: doc/BRIEF.md
# Transmit-Only Serial Byte Streamer

This block sends the contents of a byte array out on one serial data line with no command protocol. A dedicated transmit clock paces it. A second line, the clock of a bidirectional two-wire bus, selects the mode. After reset the block counts a synchronisation preamble of nine transmit-clock rising edges and keeps the data line released during it. It then sends one byte per nine transmit-clock pulses. Each frame holds eight data bits, most significant first, and then a filler bit. The byte address advances after each frame and wraps at the top of the array.

The first falling edge on the bus clock line moves the block into bidirectional mode. The data line is released at once and the block stops streaming. It stays in that mode until reset, so the neighbouring bus slave can take over the pin. Both clock lines are asynchronous to the system clock. They pass through two-stage synchronisers, and edges are found on the synchronised samples.

The array sits outside the block and is reached through a request/response read port with a fixed latency of one cycle. The block issues `rd_en_o` together with `rd_addr_o` and takes `rd_data_i` on the following cycle. The array cannot apply back-pressure. The serial output has no ready either: the receiver must keep up with the pace of the transmit clock.

Top module: `txo_byte_streamer`

## Requirements
- R1: While reset is asserted and directly after it, `sd_oe_o`, `bidir_o` and `rd_en_o` are 0.
- R2: During the first nine counted transmit-clock rising edges after reset, `sd_oe_o` stays 0.
- R3: Three system-clock cycles after the tenth counted rising edge is applied, `sd_oe_o` is 1 and `sd_o` carries bit 7 of the byte at address 0.
- R4: Each frame sends bits 7 down to 0 of its byte, one bit per rising edge. `sd_o` and `sd_oe_o` change only on the third system-clock cycle after a transmit-clock rise or a bus-clock fall is applied. Once driving, the line stays driven until a bus-clock fall.
- R5: The ninth pulse of every frame drives `sd_o` to 1.
- R6: Frames use consecutive addresses. Each `rd_en_o` lasts one cycle, carries the next address in sequence starting from 0, and is answered on `rd_data_i` in the following cycle.
- R7: After the frame for address 7Fh, the next frame sends the byte at address 00h.
- R8: A falling edge on `bus_clk_i` sets `bidir_o` to 1 and clears `sd_oe_o` three cycles later. Both then hold, whatever the transmit clock or the bus clock does, until reset.
- R9: Transmit-clock rising edges that arrive while `bus_clk_i` is low are ignored and are not counted towards the preamble.
- R10: A reset taken in bidirectional mode returns the block to transmit-only mode, and streaming restarts with the preamble and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_clk_i | input | 1 | Transmit clock, asynchronous |
| bus_clk_i | input | 1 | Bidirectional-bus clock line used as mode select, asynchronous |
| sd_o | output | 1 | Serial data value |
| sd_oe_o | output | 1 | Serial data drive enable (0 = high impedance) |
| bidir_o | output | 1 | 1 once bidirectional mode has been entered |
| rd_en_o | output | 1 | Array read request, one-cycle pulse |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_data_i | input | BITS | Array read data, valid the cycle after rd_en_o |

## Verification
A wrong preamble count appears as a whole frame shifted in time. That shift shows on the enable within three cycles of the ninth or tenth edge. A slip in the bit index shows as a wrong bit or a misplaced filler, on the very edge where it happens. An address pointer that runs ahead, or fails to wrap, breaks the read-address sequence on the next request. It also corrupts the first bit of the following frame. A mode flag that is lost or set falsely shows as the enable driving or releasing, three cycles after the bus-clock edge that caused it.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_STREAM = 2'd1,
    PH_BIDIR  = 2'd2
  } txs_phase_e;
endpackage

// File: rtl/txs_edge_sync.sv
module txs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous sample
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign level_o = pipe[STAGES-1];
  assign rise_o  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall_o  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/txs_sequencer.sv
module txs_sequencer
  import txs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BITS   = 8,
  parameter int PRE_N  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_rise_i,
  input  logic              bus_lvl_i,
  input  logic              bus_fall_i,
  output txs_phase_e        phase_o,
  output logic              load_o,
  output logic              data_step_o,
  output logic              filler_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int PRE_W = $clog2(PRE_N + 1);
  localparam int IDX_W = $clog2(BITS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_N - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BITS);

  txs_phase_e        phase;
  logic [PRE_W-1:0]  pre_cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [ADDR_W-1:0] next_addr;
  logic              act;
  logic              streaming;

  assign act       = tx_rise_i && bus_lvl_i && !bus_fall_i;
  assign streaming = (phase == PH_STREAM);

  assign load_o      = act && streaming && (bit_idx == '0);
  assign data_step_o = act && streaming && (bit_idx != IDX_LAST);
  assign filler_o    = act && streaming && (bit_idx == IDX_LAST);
  assign phase_o     = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_SYNC;
      pre_cnt   <= '0;
      bit_idx   <= '0;
      next_addr <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      rd_en_o <= 1'b0;
      if (bus_fall_i) begin
        phase <= PH_BIDIR;
      end else if (act) begin
        case (phase)
          PH_SYNC: begin
            if (pre_cnt == PRE_LAST) begin
              phase     <= PH_STREAM;
              bit_idx   <= '0;
              rd_en_o   <= 1'b1;
              rd_addr_o <= next_addr;
              next_addr <= next_addr + 1'b1;
            end else begin
              pre_cnt <= pre_cnt + 1'b1;
            end
          end
          PH_STREAM: begin
            bit_idx <= (bit_idx == IDX_LAST) ? '0 : bit_idx + 1'b1;
            if (bit_idx == '0) begin
              // prefetch the byte for the following frame
              rd_en_o   <= 1'b1;
              rd_addr_o <= next_addr;
              next_addr <= next_addr + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txs_serializer.sv
module txs_serializer #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en_i,
  input  logic [BITS-1:0] rd_data_i,
  input  logic            load_i,
  input  logic            data_step_i,
  input  logic            filler_i,
  input  logic            release_i,
  output logic            sd_o,
  output logic            sd_oe_o
);
  logic            rd_pend;
  logic [BITS-1:0] hold;
  logic [BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      hold    <= '0;
      shreg   <= '0;
      sd_o    <= 1'b1;
      sd_oe_o <= 1'b0;
    end else begin
      rd_pend <= rd_en_i;
      if (rd_pend) hold <= rd_data_i;
      if (release_i) begin
        sd_oe_o <= 1'b0;
      end else if (load_i) begin
        sd_o    <= hold[BITS-1];
        shreg   <= {hold[BITS-2:0], 1'b0};
        sd_oe_o <= 1'b1;
      end else if (data_step_i) begin
        sd_o    <= shreg[BITS-1];
        shreg   <= {shreg[BITS-2:0], 1'b0};
        sd_oe_o <= 1'b1;
      end else if (filler_i) begin
        sd_o    <= 1'b1;
        sd_oe_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txo_byte_streamer.sv
module txo_byte_streamer
  import txs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BITS        = 8,
  parameter int PRE_N       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_clk_i,
  input  logic              bus_clk_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              bidir_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BITS-1:0]   rd_data_i
);
  logic       tx_lvl, tx_rise, tx_fall;
  logic       bus_lvl, bus_rise, scl_fall;
  logic       load, data_step, filler;
  txs_phase_e phase;

  txs_edge_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .line_i(tx_clk_i),
    .level_o(tx_lvl), .rise_o(tx_rise), .fall_o(tx_fall)
  );

  txs_edge_sync #(.STAGES(SYNC_STAGES)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .line_i(bus_clk_i),
    .level_o(bus_lvl), .rise_o(bus_rise), .fall_o(scl_fall)
  );

  txs_sequencer #(.ADDR_W(ADDR_W), .BITS(BITS), .PRE_N(PRE_N)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tx_rise_i(tx_rise), .bus_lvl_i(bus_lvl), .bus_fall_i(scl_fall),
    .phase_o(phase), .load_o(load), .data_step_o(data_step), .filler_o(filler),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o)
  );

  txs_serializer #(.BITS(BITS)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .rd_en_i(rd_en_o), .rd_data_i(rd_data_i),
    .load_i(load), .data_step_i(data_step), .filler_i(filler),
    .release_i(scl_fall),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o)
  );

  assign bidir_o = (phase == PH_BIDIR);

  // edge pulses not consumed inside this block
  logic unused_edges;
  assign unused_edges = tx_lvl ^ tx_fall ^ bus_rise;
endmodule

// File: rtl/txs_checker.sv
module txs_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_rise,
  input logic scl_fall,
  input logic sd_o,
  input logic sd_oe_o,
  input logic bidir_o,
  input logic rd_en_o
);
  AST_BIDIR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_o |=> bidir_o); // R8

  AST_BIDIR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_o |-> !sd_oe_o); // R8

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rise && !scl_fall) |=> ($stable(sd_o) && $stable(sd_oe_o))); // R4

  AST_DRIVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe_o && !scl_fall) |=> sd_oe_o); // R4
endmodule

bind txo_byte_streamer txs_checker u_txs_checker (
  .clk(clk), .rst_n(rst_n), .tx_rise(tx_rise), .scl_fall(scl_fall),
  .sd_o(sd_o), .sd_oe_o(sd_oe_o), .bidir_o(bidir_o), .rd_en_o(rd_en_o)
);

// File: tb/test_txo_byte_streamer.sv
module test_txo_byte_streamer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_clk = 1'b0;
  logic       bus_clk = 1'b1;
  logic       sd, sd_oe, bidir, rd_en;
  logic [6:0] rd_addr;
  logic [7:0] rd_data = 8'h00;

  always #4 clk = ~clk;

  txo_byte_streamer i_txo_byte_streamer (
    .clk(clk), .rst_n(rst_n), .tx_clk_i(tx_clk), .bus_clk_i(bus_clk),
    .sd_o(sd), .sd_oe_o(sd_oe), .bidir_o(bidir),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] mem_f(input int a);
    return 8'((a * 29 + 90) ^ (a >> 2));
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_f(int'(rd_addr));

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int    rc = 0;
  bit    m_bidir = 0;
  bit    exp_oe = 0, exp_sd = 1, exp_bidir = 0;
  bit    p_oe, p_sd, p_bidir;
  string exp_tag = "R1", p_tag = "R1";
  int    pend_cnt = 0;
  int    exp_rd = 0, rd_seen = 0;
  bit    prev_rd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        exp_oe = p_oe; exp_sd = p_sd; exp_bidir = p_bidir; exp_tag = p_tag;
      end
    end
    if (rst_n) begin
      chk(sd_oe == exp_oe, exp_tag, "sd_oe", int'(sd_oe), int'(exp_oe));
      chk(bidir == exp_bidir, "R8", "bidir", int'(bidir), int'(exp_bidir));
      if (exp_oe) chk(sd == exp_sd, exp_tag, "sd", int'(sd), int'(exp_sd));
      if (rd_en) begin
        chk(!prev_rd, "R6", "rd_en width", 1, 0);
        chk(int'(rd_addr) == exp_rd, "R6", "rd_addr", int'(rd_addr), exp_rd);
        exp_rd = (exp_rd + 1) % 128;
        rd_seen++;
      end
      prev_rd = rd_en;
    end
  endtask

  task automatic model_rise();
    p_oe = exp_oe; p_sd = exp_sd; p_bidir = exp_bidir;
    if (m_bidir) p_tag = "R8";
    else if (!bus_clk) p_tag = "R9";
    else begin
      rc++;
      if (rc < 10) p_tag = "R2";
      else begin
        automatic int k   = (rc - 10) % 9;
        automatic int idx = ((rc - 10) / 9) % 128;
        automatic logic [7:0] b = mem_f(idx);
        p_oe = 1;
        p_sd = (k < 8) ? b[7 - k] : 1'b1;
        p_tag = (rc == 10) ? "R3" : (k == 8) ? "R5" : (idx == 0 && rc > 18) ? "R7" : "R4";
      end
    end
    pend_cnt = 3;
  endtask

  task automatic pulse();
    tx_clk = 1'b1;
    model_rise();
    repeat (4) tick();
    tx_clk = 1'b0;
    repeat (4) tick();
  endtask

  task automatic bus_drop();
    bus_clk = 1'b0;
    m_bidir = 1;
    p_oe = 0; p_sd = exp_sd; p_bidir = 1; p_tag = "R8";
    pend_cnt = 3;
    repeat (6) tick();
  endtask

  task automatic bus_raise();
    bus_clk = 1'b1;
    repeat (6) tick();
  endtask

  task automatic do_reset(input bit bus_val, input string tag);
    rst_n = 1'b0; tx_clk = 1'b0; bus_clk = bus_val;
    rc = 0; m_bidir = 0; exp_oe = 0; exp_bidir = 0; exp_tag = tag;
    exp_rd = 0; prev_rd = 0; pend_cnt = 0;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    do_reset(1'b1, "R1");
    chk(!sd_oe && !bidir && !rd_en, "R1", "reset outputs", int'({sd_oe, bidir, rd_en}), 0);

    repeat (9) pulse();
    chk(sd_oe == 0, "R2", "oe after preamble", int'(sd_oe), 0);
    pulse();
    chk(sd_oe && sd == mem_f(0)[7], "R3", "first bit", int'({sd_oe, sd}), int'({1'b1, mem_f(0)[7]}));
    repeat (8) pulse();
    chk(sd == 1'b1, "R5", "filler", int'(sd), 1);
    repeat (9) pulse();
    chk(sd == 1'b1, "R4", "second frame end", int'(sd), 1);
    while (rc < 10 + 9 * 128) pulse();
    chk(sd == mem_f(0)[7], "R7", "wrap first bit", int'(sd), int'(mem_f(0)[7]));
    repeat (9) pulse();
    chk(rd_seen >= 130, "R6", "reads issued", rd_seen, 130);

    bus_drop();
    chk(!sd_oe && bidir, "R8", "enter bidir", int'({sd_oe, bidir}), 1);
    repeat (12) pulse();
    bus_raise();
    bus_drop();
    chk(!sd_oe && bidir, "R8", "bidir held", int'({sd_oe, bidir}), 1);

    do_reset(1'b0, "R10");
    chk(!bidir, "R10", "bidir cleared", int'(bidir), 0);
    repeat (12) pulse();
    chk(sd_oe == 0, "R9", "rises with bus low", int'(sd_oe), 0);
    bus_raise();
    repeat (9) pulse();
    chk(sd_oe == 0, "R9", "preamble restarted", int'(sd_oe), 0);
    pulse();
    chk(sd_oe && sd == mem_f(0)[7] && !bidir, "R10", "restart at 0",
        int'({sd_oe, sd, bidir}), int'({1'b1, mem_f(0)[7], 1'b0}));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule